// File: doc/BRIEF.md
# March C- Memory Self-Test Controller

This block is a built-in self-test engine that exercises a synchronous single-port memory with the March C- algorithm. The array is addressed by a row field and a column field. The engine drives the row, column, write-enable, read-enable and write-data lines itself, and it compares every returned read word against the value the algorithm expects. A start pulse launches a run. A scan-order input, sampled at start, chooses whether the row or the column index moves fastest.

While the run is in progress, busy is raised. At the end, a one-cycle done pulse appears. The fail flag, the location and data of the first miscompare, and a saturating count of all miscompares stay valid until the next start. Stuck-at, transition, coupling and address-decoder faults show up as a read of the wrong polarity.

Top module: `march_bist`

## Requirements
- R1: A run issues six elements in this order, indexed 0 to 5: element 0 writes 0; element 1 reads 0 then writes 1; element 2 reads 1 then writes 0; element 3 reads 0 then writes 1; element 4 reads 1 then writes 0; element 5 reads 0. A written value and an expected value of v mean the word with every bit equal to v.
- R2: A run on an array of N = 2^(ROW_W+COL_W) cells makes exactly 10·N memory accesses, one per cycle, and never asserts write and read enables in the same cycle.
- R3: With scan_y_i = 0 at start (row-fast), the row index advances first, and the column index moves only when the row wraps.
- R4: With scan_y_i = 1 at start (column-fast), the column index advances first, and the row index moves only when the column wraps.
- R5: Elements 0, 1, 2 and 5 walk addresses upward from row 0, column 0. Elements 3 and 4 walk downward from all-ones, stepping the same fast index in reverse.
- R6: In a read-then-write element, the write goes to the same row and column as the read just before it. The read word is taken on mem_rdata_i in the cycle after mem_re_o.
- R7: Any read word that differs from its expected value sets fail_o. A fault-free array finishes with fail_o = 0 and err_cnt_o = 0.
- R8: The first miscompare of a run latches its row, column, element index and observed word on fail_row_o, fail_col_o, fail_elem_o and fail_data_o. Later miscompares leave these unchanged.
- R9: err_cnt_o counts miscompares and saturates at its all-ones value.
- R10: busy_o is high from the cycle after an accepted start until the run ends. done_o is high for exactly one cycle after the last compare. The results hold until the next accepted start, which clears them.
- R11: A start pulse while busy_o is high is ignored, along with the scan_y_i value presented with it.
- R12: A cell stuck at 1 on one bit, a cell that cannot rise on one bit, and an address that decodes onto another cell each end the run with fail_o = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| scan_y_i | input | 1 | Scan order at start: 0 row-fast, 1 column-fast |
| mem_row_o | output | ROW_W | Memory row address |
| mem_col_o | output | COL_W | Memory column address |
| mem_we_o | output | 1 | Memory write enable |
| mem_re_o | output | 1 | Memory read enable |
| mem_wdata_o | output | DATA_W | Memory write word |
| mem_rdata_i | input | DATA_W | Memory read word, valid one cycle after mem_re_o |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| fail_o | output | 1 | At least one miscompare in the last run |
| fail_row_o | output | ROW_W | Row of the first miscompare |
| fail_col_o | output | COL_W | Column of the first miscompare |
| fail_elem_o | output | 3 | Element index of the first miscompare |
| fail_data_o | output | DATA_W | Word observed at the first miscompare |
| err_cnt_o | output | ERR_W | Saturating miscompare count |

## Verification
The full access stream of a fault-free array is recorded in both scan orders and compared op by op against an independently generated March C- list. This separates a wrong element order, a wrong scan direction, a missed reversal in elements 3 and 4, and any extra or missing access. A single-bit stuck-at-1 cell is expected to fail first in element 1, with three miscompares, in either scan order. A cell that cannot rise is expected to fail first in element 2, with two. An address that aliases onto an earlier cell is expected to fail at the aliased address in element 1. These three faults tell the two read polarities and the address decoding apart. A whole array stuck at 0 drives the counter past its limit. A start pulse with a flipped scan order, given in the middle of a run, must leave the stream unchanged.

// File: rtl/march_pkg.sv
package march_pkg;
  localparam int ELEM_W = 3;
  localparam logic [ELEM_W-1:0] LAST_ELEM = 3'd5;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DRAIN} seq_state_e;

  // elements 1..4 are read-then-write
  function automatic logic elem_two_op(input logic [ELEM_W-1:0] e);
    return (e >= 3'd1) && (e <= 3'd4);
  endfunction

  // value expected by the read of an element
  function automatic logic elem_rd_val(input logic [ELEM_W-1:0] e);
    return (e == 3'd2) || (e == 3'd4);
  endfunction

  function automatic logic elem_down(input logic [ELEM_W-1:0] e);
    return (e == 3'd3) || (e == 3'd4);
  endfunction
endpackage

// File: rtl/march_addr_gen.sv
module march_addr_gen #(
  parameter int ROW_W = 3,
  parameter int COL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scan_y_i,
  input  logic             load_i,
  input  logic             load_down_i,
  input  logic             step_i,
  output logic [ROW_W-1:0] row_o,
  output logic [COL_W-1:0] col_o,
  output logic             last_o
);
  logic [ROW_W-1:0] row_q, row_n;
  logic [COL_W-1:0] col_q, col_n;
  logic             down_q;
  logic             row_wrap, col_wrap;

  assign row_wrap = down_q ? (row_q == '0) : (&row_q);
  assign col_wrap = down_q ? (col_q == '0) : (&col_q);
  assign last_o   = row_wrap && col_wrap;

  always_comb begin
    row_n = row_q;
    col_n = col_q;
    if (!scan_y_i) begin
      row_n = down_q ? row_q - 1'b1 : row_q + 1'b1;
      if (row_wrap) col_n = down_q ? col_q - 1'b1 : col_q + 1'b1;
    end else begin
      col_n = down_q ? col_q - 1'b1 : col_q + 1'b1;
      if (col_wrap) row_n = down_q ? row_q - 1'b1 : row_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q  <= '0;
      col_q  <= '0;
      down_q <= 1'b0;
    end else if (load_i) begin
      row_q  <= load_down_i ? '1 : '0;
      col_q  <= load_down_i ? '1 : '0;
      down_q <= load_down_i;
    end else if (step_i) begin
      row_q <= row_n;
      col_q <= col_n;
    end
  end

  assign row_o = row_q;
  assign col_o = col_q;
endmodule

// File: rtl/march_seq.sv
module march_seq
  import march_pkg::*;
#(
  parameter int ROW_W = 3,
  parameter int COL_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              scan_y_i,
  output logic [ROW_W-1:0]  row_o,
  output logic [COL_W-1:0]  col_o,
  output logic              we_o,
  output logic              re_o,
  output logic              bit_o,
  output logic [ELEM_W-1:0] elem_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              clear_o
);
  seq_state_e        state_q;
  logic [ELEM_W-1:0] elem_q;
  logic              phase_q, scan_q, done_q;
  logic              running, start_acc, two_op, is_rd, adv, last, load, load_down, step;

  assign running   = (state_q == S_RUN);
  assign start_acc = (state_q == S_IDLE) && start_i;
  assign two_op    = elem_two_op(elem_q);
  assign is_rd     = (elem_q != '0) && !phase_q;
  assign adv       = running && (phase_q || !two_op);
  assign load      = start_acc || (adv && last && (elem_q != LAST_ELEM));
  assign load_down = start_acc ? 1'b0 : elem_down(elem_q + 3'd1);
  assign step      = adv && !last;

  march_addr_gen #(.ROW_W(ROW_W), .COL_W(COL_W)) u_addr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scan_y_i   (scan_q),
    .load_i     (load),
    .load_down_i(load_down),
    .step_i     (step),
    .row_o      (row_o),
    .col_o      (col_o),
    .last_o     (last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      elem_q  <= '0;
      phase_q <= 1'b0;
      scan_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= (state_q == S_DRAIN);
      case (state_q)
        S_IDLE: if (start_i) begin
          state_q <= S_RUN;
          elem_q  <= '0;
          phase_q <= 1'b0;
          scan_q  <= scan_y_i;
        end
        S_RUN: begin
          if (two_op && !phase_q) phase_q <= 1'b1;
          else begin
            phase_q <= 1'b0;
            if (last) begin
              if (elem_q == LAST_ELEM) state_q <= S_DRAIN;
              else                     elem_q  <= elem_q + 3'd1;
            end
          end
        end
        default: state_q <= S_IDLE;  // drain: last compare lands this cycle
      endcase
    end
  end

  assign we_o    = running && !is_rd;
  assign re_o    = running && is_rd;
  assign bit_o   = is_rd ? elem_rd_val(elem_q) : (phase_q && !elem_rd_val(elem_q));
  assign elem_o  = elem_q;
  assign busy_o  = (state_q != S_IDLE);
  assign done_o  = done_q;
  assign clear_o = start_acc;
endmodule

// File: rtl/march_cmp.sv
module march_cmp
  import march_pkg::*;
#(
  parameter int ROW_W  = 3,
  parameter int COL_W  = 2,
  parameter int DATA_W = 8,
  parameter int ERR_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              rd_i,
  input  logic              exp_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [ELEM_W-1:0] elem_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              fail_o,
  output logic [ROW_W-1:0]  fail_row_o,
  output logic [COL_W-1:0]  fail_col_o,
  output logic [ELEM_W-1:0] fail_elem_o,
  output logic [DATA_W-1:0] fail_data_o,
  output logic [ERR_W-1:0]  err_cnt_o
);
  logic              pend_q, exp_q, fail_q;
  logic [ROW_W-1:0]  prow_q, frow_q;
  logic [COL_W-1:0]  pcol_q, fcol_q;
  logic [ELEM_W-1:0] pelem_q, felem_q;
  logic [DATA_W-1:0] fdata_q;
  logic [ERR_W-1:0]  err_q;
  logic              mism;

  assign mism = pend_q && (rdata_i != {DATA_W{exp_q}});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      exp_q   <= 1'b0;
      prow_q  <= '0;
      pcol_q  <= '0;
      pelem_q <= '0;
      fail_q  <= 1'b0;
      frow_q  <= '0;
      fcol_q  <= '0;
      felem_q <= '0;
      fdata_q <= '0;
      err_q   <= '0;
    end else if (clear_i) begin
      pend_q  <= 1'b0;
      fail_q  <= 1'b0;
      frow_q  <= '0;
      fcol_q  <= '0;
      felem_q <= '0;
      fdata_q <= '0;
      err_q   <= '0;
    end else begin
      pend_q <= rd_i;
      if (rd_i) begin
        exp_q   <= exp_i;
        prow_q  <= row_i;
        pcol_q  <= col_i;
        pelem_q <= elem_i;
      end
      if (mism) begin
        fail_q <= 1'b1;
        if (!fail_q) begin
          frow_q  <= prow_q;
          fcol_q  <= pcol_q;
          felem_q <= pelem_q;
          fdata_q <= rdata_i;
        end
        if (err_q != '1) err_q <= err_q + 1'b1;
      end
    end
  end

  assign fail_o      = fail_q;
  assign fail_row_o  = frow_q;
  assign fail_col_o  = fcol_q;
  assign fail_elem_o = felem_q;
  assign fail_data_o = fdata_q;
  assign err_cnt_o   = err_q;
endmodule

// File: rtl/march_bist.sv
module march_bist
  import march_pkg::*;
#(
  parameter int ROW_W  = 3,
  parameter int COL_W  = 2,
  parameter int DATA_W = 8,
  parameter int ERR_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              scan_y_i,
  output logic [ROW_W-1:0]  mem_row_o,
  output logic [COL_W-1:0]  mem_col_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              fail_o,
  output logic [ROW_W-1:0]  fail_row_o,
  output logic [COL_W-1:0]  fail_col_o,
  output logic [2:0]        fail_elem_o,
  output logic [DATA_W-1:0] fail_data_o,
  output logic [ERR_W-1:0]  err_cnt_o
);
  logic              op_bit, clear;
  logic [ELEM_W-1:0] elem;

  march_seq #(.ROW_W(ROW_W), .COL_W(COL_W)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .scan_y_i(scan_y_i),
    .row_o   (mem_row_o),
    .col_o   (mem_col_o),
    .we_o    (mem_we_o),
    .re_o    (mem_re_o),
    .bit_o   (op_bit),
    .elem_o  (elem),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .clear_o (clear)
  );

  assign mem_wdata_o = {DATA_W{op_bit}};

  march_cmp #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .ERR_W(ERR_W)) u_cmp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (clear),
    .rd_i       (mem_re_o),
    .exp_i      (op_bit),
    .row_i      (mem_row_o),
    .col_i      (mem_col_o),
    .elem_i     (elem),
    .rdata_i    (mem_rdata_i),
    .fail_o     (fail_o),
    .fail_row_o (fail_row_o),
    .fail_col_o (fail_col_o),
    .fail_elem_o(fail_elem_o),
    .fail_data_o(fail_data_o),
    .err_cnt_o  (err_cnt_o)
  );
endmodule

// File: rtl/march_bist_chk.sv
module march_bist_chk #(
  parameter int ROW_W  = 3,
  parameter int COL_W  = 2,
  parameter int DATA_W = 8,
  parameter int ERR_W  = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [ROW_W-1:0] mem_row_o,
  input logic [COL_W-1:0] mem_col_o,
  input logic             mem_we_o,
  input logic             mem_re_o,
  input logic             busy_o,
  input logic             done_o,
  input logic             fail_o,
  input logic [ERR_W-1:0] err_cnt_o
);
  p_one_access_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && mem_re_o));

  p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_we_o && !mem_re_o);

  p_rw_same_addr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |=> !mem_we_o || (mem_row_o == $past(mem_row_o) && mem_col_o == $past(mem_col_o)));

  p_err_no_drop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> err_cnt_o >= $past(err_cnt_o));

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  p_result_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(fail_o) && $stable(err_cnt_o));
endmodule

bind march_bist march_bist_chk #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .ERR_W(ERR_W)) u_chk (.*);

// File: tb/tb_march_bist.sv
`timescale 1ns/1ps
module tb_march_bist;
  localparam int ROW_W  = 3;
  localparam int COL_W  = 2;
  localparam int DATA_W = 8;
  localparam int ERR_W  = 6;
  localparam int ROWS   = 1 << ROW_W;
  localparam int COLS   = 1 << COL_W;
  localparam int N      = ROWS * COLS;
  localparam int OPS    = 10 * N;

  logic clk = 1'b0, rst_ni = 1'b0, start = 1'b0, scan_y = 1'b0;
  logic [ROW_W-1:0]  mem_row, fail_row;
  logic [COL_W-1:0]  mem_col, fail_col;
  logic              mem_we, mem_re, busy, done, fail;
  logic [DATA_W-1:0] mem_wdata, mem_rdata, fail_data;
  logic [2:0]        fail_elem;
  logic [ERR_W-1:0]  err_cnt;

  always #2 clk = ~clk;

  march_bist #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .ERR_W(ERR_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .scan_y_i(scan_y),
    .mem_row_o(mem_row), .mem_col_o(mem_col), .mem_we_o(mem_we), .mem_re_o(mem_re),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .busy_o(busy), .done_o(done),
    .fail_o(fail), .fail_row_o(fail_row), .fail_col_o(fail_col), .fail_elem_o(fail_elem),
    .fail_data_o(fail_data), .err_cnt_o(err_cnt));

  // memory model with fault injection: 0 none, 1 stuck-at-1 bit, 2 no-rise bit, 3 alias, 4 all stuck at 0
  logic [DATA_W-1:0] mem [N];
  int fkind = 0, fcell = 0, fbit = 0, alias_src = 0, alias_dst = 0;

  function automatic int phys(input int a);
    return (fkind == 3 && a == alias_src) ? alias_dst : a;
  endfunction

  always @(posedge clk) begin
    int a;
    logic [DATA_W-1:0] v;
    a = phys(int'({mem_row, mem_col}));
    if (mem_we) begin
      v = mem_wdata;
      if (fkind == 4) v = '0;
      if (fkind == 2 && a == fcell && !mem[a][fbit]) v[fbit] = 1'b0;
      mem[a] <= v;
    end
    if (mem_re) begin
      v = mem[a];
      if (fkind == 1 && a == fcell) v[fbit] = 1'b1;
      if (fkind == 4) v = '0;
      mem_rdata <= v;
    end
  end

  // access recorder
  logic rec_en = 1'b0;
  int   rec_n = 0;
  logic rec_we [OPS];
  int   rec_row [OPS], rec_col [OPS];
  logic rec_bit [OPS];
  always @(posedge clk) begin
    if (rec_en && (mem_we || mem_re)) begin
      if (rec_n < OPS) begin
        rec_we[rec_n]  <= mem_we;
        rec_row[rec_n] <= int'(mem_row);
        rec_col[rec_n] <= int'(mem_col);
        rec_bit[rec_n] <= mem_we ? (mem_wdata == {DATA_W{mem_wdata[0]}} ? mem_wdata[0] : 1'bx) : 1'b0;
      end
      rec_n <= rec_n + 1;
    end
  end

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // one run; mid >= 0 pulses start with flipped scan order at that cycle
  int done_len;
  task automatic run_march(input logic scan, input int mid);
    int cyc;
    rec_n = 0;
    @(negedge clk);
    rec_en = 1'b1;
    start = 1'b1;
    scan_y = scan;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 2000) begin
      @(negedge clk);
      cyc++;
      start = (cyc == mid);
      if (cyc == mid) scan_y = ~scan;
    end
    start = 1'b0;
    chk(cyc < 2000, "R10", "run completes", cyc, 2000);
    done_len = 0;
    while (done && done_len < 5) begin
      done_len++;
      @(negedge clk);
    end
    rec_en = 1'b0;
  endtask

  // compare recorded accesses with independently generated March C- list
  task automatic check_seq(input logic scan, input string req);
    int idx = 0, bad = 0, first_bad = -1;
    for (int e = 0; e < 6; e++) begin
      bit down = (e == 3 || e == 4);
      bit rdv  = (e == 2 || e == 4);
      for (int k = 0; k < N; k++) begin
        int fast_n = scan ? COLS : ROWS;
        int f = down ? fast_n - 1 - (k % fast_n) : k % fast_n;
        int s = down ? (N / fast_n) - 1 - (k / fast_n) : k / fast_n;
        int r = scan ? s : f;
        int c = scan ? f : s;
        for (int p = 0; p < 2; p++) begin
          bit op_rd;
          bit wv;
          if (p == 1 && !(e >= 1 && e <= 4)) continue;
          op_rd = (e != 0) && (p == 0);
          wv = (e == 0) ? 1'b0 : !rdv;
          if (idx < OPS) begin
            if (rec_we[idx] !== !op_rd || rec_row[idx] != r || rec_col[idx] != c ||
                (!op_rd && rec_bit[idx] !== wv)) begin
              bad++;
              if (first_bad < 0) first_bad = idx;
            end
          end
          idx++;
        end
      end
    end
    chk(bad == 0, req, "access stream first mismatching op index", first_bad, -1);
    chk(rec_n == OPS, "R2", "access count", rec_n, OPS);
  endtask

  task automatic clear_faults();
    fkind = 0;
  endtask

  task automatic t_reset();
    chk(!busy && !done, "R10", "busy/done after reset", {busy, done}, 0);
    chk(!fail && err_cnt == 0, "R7", "fail/count after reset", int'(err_cnt), 0);
    chk(!mem_we && !mem_re, "R2", "no access after reset", {mem_we, mem_re}, 0);
  endtask

  task automatic t_clean_x();
    clear_faults();
    run_march(1'b0, -1);
    check_seq(1'b0, "R1 R3 R5");
    chk(!fail && err_cnt == 0, "R7", "clean array row-fast passes", int'(err_cnt), 0);
    chk(done_len == 1, "R10", "done pulse width", done_len, 1);
  endtask

  task automatic t_clean_y();
    clear_faults();
    run_march(1'b1, -1);
    check_seq(1'b1, "R1 R4 R5");
    chk(!fail && err_cnt == 0, "R7", "clean array column-fast passes", int'(err_cnt), 0);
  endtask

  task automatic t_stuck(input logic scan);
    fkind = 1; fcell = 5 * COLS + 2; fbit = 3;
    run_march(scan, -1);
    chk(fail, "R12", "stuck-at detected", fail, 1);
    chk(fail_row == 5 && fail_col == 2, "R8", "stuck first address", {fail_row, fail_col}, {3'd5, 2'd2});
    chk(fail_elem == 3'd1, "R8", "stuck first element", fail_elem, 1);
    chk(fail_data == 8'h08, "R8", "stuck observed word", fail_data, 8'h08);
    chk(err_cnt == 3, "R9", "stuck miscompare count", err_cnt, 3);
    repeat (6) @(negedge clk);
    chk(fail && err_cnt == 3 && !busy, "R10", "results held while idle", err_cnt, 3);
    clear_faults();
  endtask

  task automatic t_transition();
    fkind = 2; fcell = 1 * COLS + 3; fbit = 6;
    run_march(1'b0, -1);
    chk(fail, "R12", "transition fault detected", fail, 1);
    chk(fail_elem == 3'd2 && fail_row == 1 && fail_col == 3, "R8", "transition first elem/addr",
        {fail_elem, fail_row, fail_col}, {3'd2, 3'd1, 2'd3});
    chk(fail_data == 8'hBF, "R8", "transition observed word", fail_data, 8'hBF);
    chk(err_cnt == 2, "R9", "transition miscompare count", err_cnt, 2);
    clear_faults();
  endtask

  task automatic t_alias();
    fkind = 3; alias_dst = 0; alias_src = 2 * COLS + 1;
    run_march(1'b0, -1);
    chk(fail, "R12", "alias fault detected", fail, 1);
    chk(fail_elem == 3'd1 && fail_row == 2 && fail_col == 1, "R8", "alias first elem/addr",
        {fail_elem, fail_row, fail_col}, {3'd1, 3'd2, 2'd1});
    chk(fail_data == 8'hFF, "R6", "alias word read the cycle after read enable", fail_data, 8'hFF);
    clear_faults();
  endtask

  task automatic t_saturate();
    fkind = 4;
    run_march(1'b0, -1);
    chk(err_cnt == {ERR_W{1'b1}}, "R9", "count saturates (64 miscompares)", err_cnt, 63);
    chk(fail_elem == 3'd2 && fail_row == 0 && fail_col == 0 && fail_data == 0, "R8",
        "first capture kept", {fail_elem, fail_row, fail_col}, {3'd2, 3'd0, 2'd0});
    clear_faults();
    run_march(1'b0, -1);
    chk(!fail && err_cnt == 0, "R10", "next start clears results", err_cnt, 0);
  endtask

  task automatic t_busy_start();
    clear_faults();
    run_march(1'b0, 50);
    check_seq(1'b0, "R11");
    chk(!fail, "R11", "mid-run start ignored, run passes", fail, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_clean_x();
    t_clean_y();
    t_stuck(1'b0);
    t_stuck(1'b1);
    t_transition();
    t_alias();
    t_saturate();
    t_busy_start();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    end
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    end
    $finish;
  end
endmodule